// File: doc/BRIEF.md
# Line-21 Caption Waveform Inserter

This block produces the NRZ caption waveform that rides on the designated vertical-blanking line of an NTSC-style luma stream. Each field carries its own channel: the first field carries the caption channel and the second field carries the extended-data channel. A host writes two bytes per channel through a small register interface. On the target line the block sends a seven-cycle clock run-in, a start framing and the two bytes, and produces one luma code per sample together with a valid flag. That flag tells the downstream mixer to take this value in place of incoming pixel data.

Host writes go into a staging buffer. The buffer is moved into use only at the first sample of the next target line of that channel, so a burst never mixes old and new bytes. A per-channel status flag shows whether written bytes are still waiting to be encoded. A gate mode decides what goes out when the host has not refreshed a channel. With the gate set, fresh bytes are sent once and then the null pair (0x80, 0x80) follows. With the gate cleared, the last bytes are repeated every frame. A teletext-active input takes the line away from the block sample by sample.

The bit clock comes from a fractional phase accumulator at the sample clock. The default step gives 32 bits per line period at 27 MHz. The host can trim the step and move the burst start point.

Top module: `caption_inserter`

## Requirements
- R1: A burst lasts 26 bit periods, sent in this order. Periods 0..6 are run-in: 126 during the first half of each period and 16 during the second half. Periods 7 and 8 are 0 and period 9 is 1. Periods 10..17 carry byte A and periods 18..25 carry byte B, each least significant bit first.
- R2: NRZ coding: a 1 bit drives luma code 126 and a 0 bit drives code 16. Every valid sample outside a burst on the target line is 16.
- R3: Bit timing: let the phase step be 1222 plus the signed 8-bit trim held at register 6. After the edge that samples count start+m (m >= 1), the output shows bit period floor((m-1)*step/65536). The run-in half is given by bit 15 of that product (0 means first half).
- R4: The burst begins at the edge where targetLine is 1 and sampleCount equals 4 times the 8-bit value held at register 5. That value is 71 after reset.
- R5: No parity is computed: bit 7 of each byte is sent exactly as written.
- R6: Writes are staged. A pair written to register 0 (caption byte A) and register 1 (caption byte B), or to register 2 (extended-data byte A) and register 3 (extended-data byte B), is taken into use at sampleCount 0 of the next target line of that channel. A target line of the other channel leaves the pair pending.
- R7: With the gate (register 4 bit 0) at 1, freshly taken bytes are sent on one line. Later lines of that channel send 0x80, 0x80 until new bytes are written.
- R8: With the gate at 0, the last bytes taken into use are sent again on every line of that channel.
- R9: Register 7 reads status: bit 0 is caption and bit 1 is extended-data. A bit goes to 1 the cycle after its byte-B register is written. It returns to 0 when the burst that carried those bytes ends.
- R10: On a sample where ttxActive is 1, the next output has lumaValid at 0 and lumaOut at 16.
- R11: lumaValid is 1 one cycle after a sample with targetLine at 1 and ttxActive at 0. It is 0 one cycle after a sample with targetLine at 0.
- R12: fieldOdd at 1 selects the caption channel for the target line and fieldOdd at 0 selects the extended-data channel.
- R13: After reset: the gate reads 1, register 5 reads 71, register 6 reads 0, status reads 0, lumaOut is 16, lumaValid is 0, and both channels hold 0x80, 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | 3 | Host register address |
| regWdata | input | 8 | Host write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| targetLine | input | 1 | High for every sample of the caption line |
| fieldOdd | input | 1 | 1 on the first field (caption), 0 on the second (extended data) |
| sampleCount | input | 11 | Sample index within the line |
| ttxActive | input | 1 | Teletext owns this sample |
| lumaOut | output | 8 | Luma override code |
| lumaValid | output | 1 | lumaOut replaces pixel data |

## Verification
The bench goes after the gate corners. A design that kept resending fresh bytes with the gate set would show the old pair instead of 0x80 on the second line. One that fell back to null with the gate cleared would lose the repeat. It also runs a line of the other field while a pair is pending. A design without a per-channel commit would send or clear the wrong channel, and the status bit would drop early. The edge cases of timing are covered by trimmed steps and moved start points, where an off-by-one in the accumulator or the start compare shifts every edge by one sample. Teletext windows that land in mid-burst catch a design that lets the caption override win.

// File: rtl/capt_pkg.sv
package capt_pkg;
  localparam int RUNIN_BITS = 7;
  localparam int BURST_BITS = 26;
  localparam int CNT_W      = $clog2(BURST_BITS);
  localparam int FRAME_W    = BURST_BITS - RUNIN_BITS;

  localparam logic [7:0] NULL_BYTE = 8'h80;

  localparam logic [2:0] ADDR_GATE   = 3'd4;
  localparam logic [2:0] ADDR_START  = 3'd5;
  localparam logic [2:0] ADDR_TRIM   = 3'd6;
  localparam logic [2:0] ADDR_STATUS = 3'd7;

  typedef struct packed {
    logic load;        // first cycle of a burst: take the byte pair
    logic active;      // burst in progress
    logic runIn;       // current bit period belongs to the run-in
    logic secondHalf;  // phase past the middle of the bit period
    logic advance;     // a data bit period ends on this edge
  } capStrobe_t;
endpackage

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int SAMPLE_W      = 11,
  parameter int PHASE_W       = 16,
  parameter int BASE_STEP     = 1222,
  parameter int START_SHIFT   = 2,
  parameter int START_DEFAULT = 71
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWe,
  input  logic [2:0]          regAddr,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  input  logic                targetLine,
  input  logic                fieldOdd,
  input  logic [SAMPLE_W-1:0] sampleCount,
  output capStrobe_t          strobe,
  output logic [7:0]          sendA,
  output logic [7:0]          sendB
);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BURST_BITS - 1);
  localparam logic [CNT_W-1:0] RUNIN_END = CNT_W'(RUNIN_BITS);

  logic                gateMode;
  logic [7:0]          startReg;
  logic [7:0]          trimReg;
  logic [1:0][7:0]     stgA, stgB, actA, actB;
  logic [1:0]          pendW, freshW, statusW;

  logic                active;
  logic [PHASE_W-1:0]  acc;
  logic [CNT_W-1:0]    bitCnt;
  logic                burstCh;

  logic                curCh;
  logic                lineOpen;
  logic                startNow;
  logic [SAMPLE_W-1:0] startPos;
  logic [PHASE_W-1:0]  step;
  logic [PHASE_W:0]    accSum;
  logic                carry;
  logic                burstDone;

  assign curCh    = ~fieldOdd;
  assign lineOpen = targetLine && (sampleCount == '0);
  assign startPos = SAMPLE_W'(startReg) << START_SHIFT;
  assign startNow = targetLine && (sampleCount == startPos) && !active;
  assign step     = PHASE_W'(BASE_STEP) + {{(PHASE_W-8){trimReg[7]}}, trimReg};
  assign accSum   = {1'b0, acc} + {1'b0, step};
  assign carry    = active && accSum[PHASE_W];
  assign burstDone = carry && (bitCnt == LAST_BIT);

  // Host control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateMode <= 1'b1;
      startReg <= 8'(START_DEFAULT);
      trimReg  <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_GATE)  gateMode <= regWdata[0];
      if (regAddr == ADDR_START) startReg <= regWdata;
      if (regAddr == ADDR_TRIM)  trimReg  <= regWdata;
    end
  end

  // Per-channel staging and in-use byte buffers
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam logic [2:0] ADDR_A = 3'(2 * ch);
    localparam logic [2:0] ADDR_B = 3'(2 * ch + 1);
    logic [7:0] sA, sB, aA, aB;
    logic       pend, frsh;
    logic       writeB, commit;

    assign writeB = regWe && (regAddr == ADDR_B);
    assign commit = lineOpen && (curCh == 1'(ch)) && pend;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sA   <= NULL_BYTE;
        sB   <= NULL_BYTE;
        aA   <= NULL_BYTE;
        aB   <= NULL_BYTE;
        pend <= 1'b0;
        frsh <= 1'b0;
      end else begin
        if (regWe && (regAddr == ADDR_A)) sA <= regWdata;
        if (writeB) sB <= regWdata;
        if (commit) begin
          aA <= sA;
          aB <= sB;
        end
        if (writeB)      pend <= 1'b1;
        else if (commit) pend <= 1'b0;
        if (commit)                                frsh <= 1'b1;
        else if (burstDone && burstCh == 1'(ch))   frsh <= 1'b0;
      end
    end

    assign stgA[ch]    = sA;
    assign stgB[ch]    = sB;
    assign actA[ch]    = aA;
    assign actB[ch]    = aB;
    assign pendW[ch]   = pend;
    assign freshW[ch]  = frsh;
    assign statusW[ch] = pend | frsh;
  end

  // Pair chosen for the coming burst, decided at the line's first sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sendA <= NULL_BYTE;
      sendB <= NULL_BYTE;
    end else if (lineOpen) begin
      if (pendW[curCh]) begin
        sendA <= stgA[curCh];
        sendB <= stgB[curCh];
      end else if (gateMode) begin
        sendA <= NULL_BYTE;
        sendB <= NULL_BYTE;
      end else begin
        sendA <= actA[curCh];
        sendB <= actB[curCh];
      end
    end
  end

  // Burst sequencer with fractional bit clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      acc     <= '0;
      bitCnt  <= '0;
      burstCh <= 1'b0;
    end else if (startNow) begin
      active  <= 1'b1;
      acc     <= '0;
      bitCnt  <= '0;
      burstCh <= curCh;
    end else if (active) begin
      acc <= accSum[PHASE_W-1:0];
      if (carry) begin
        if (bitCnt == LAST_BIT) active <= 1'b0;
        else                    bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.load       = startNow;
    strobe.active     = active;
    strobe.runIn      = bitCnt < RUNIN_END;
    strobe.secondHalf = acc[PHASE_W-1];
    strobe.advance    = carry && (bitCnt >= RUNIN_END);
  end

  always_comb begin
    unique case (regAddr)
      3'd0:        regRdata = stgA[0];
      3'd1:        regRdata = stgB[0];
      3'd2:        regRdata = stgA[1];
      3'd3:        regRdata = stgB[1];
      ADDR_GATE:   regRdata = {7'd0, gateMode};
      ADDR_START:  regRdata = startReg;
      ADDR_TRIM:   regRdata = trimReg;
      default:     regRdata = {6'd0, statusW};
    endcase
  end

  // R9: writing caption byte B raises the caption status bit
  a_r9_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == 3'd1) |=> statusW[0]);

  // R4: a burst only starts on the target line at the programmed sample
  a_r4_start_point: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(targetLine) && $past(sampleCount) == $past(startPos)));

  // R1: a burst always ends after its last bit period
  a_r1_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(bitCnt) == LAST_BIT);

  // R6: the pair in use does not change while a burst is running
  a_r6_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !lineOpen) |=> ($stable(sendA) && $stable(sendB)));
endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter logic [7:0] LEVEL_HIGH = 8'd126,
  parameter logic [7:0] LEVEL_LOW  = 8'd16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  capStrobe_t strobe,
  input  logic [7:0] sendA,
  input  logic [7:0] sendB,
  input  logic       targetLine,
  input  logic       ttxActive,
  output logic [7:0] lumaOut,
  output logic       lumaValid
);
  logic [FRAME_W-1:0] frameSr;
  logic               bitLevel;
  logic               ownSample;

  // Start framing 0,0,1 then byte A and byte B, LSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              frameSr <= '0;
    else if (strobe.load)    frameSr <= {sendB, sendA, 3'b100};
    else if (strobe.advance) frameSr <= frameSr >> 1;
  end

  always_comb begin
    if (!strobe.active)    bitLevel = 1'b0;
    else if (strobe.runIn) bitLevel = ~strobe.secondHalf;
    else                   bitLevel = frameSr[0];
  end

  assign ownSample = targetLine && !ttxActive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lumaOut   <= LEVEL_LOW;
      lumaValid <= 1'b0;
    end else begin
      lumaValid <= ownSample;
      lumaOut   <= (ownSample && bitLevel) ? LEVEL_HIGH : LEVEL_LOW;
    end
  end

  // R2: only the two NRZ codes ever appear
  a_r2_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (lumaOut == LEVEL_LOW) || (lumaOut == LEVEL_HIGH));

  // R10: teletext on a sample removes the override on the next output
  a_r10_ttx_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ttxActive |=> (!lumaValid && lumaOut == LEVEL_LOW));

  // R11: no override off the target line
  a_r11_off_line: assert property (@(posedge clk) disable iff (!rst_n)
    !targetLine |=> !lumaValid);
endmodule

// File: rtl/caption_inserter.sv
module caption_inserter
  import capt_pkg::*;
#(
  parameter int         SAMPLE_W      = 11,
  parameter int         PHASE_W       = 16,
  parameter int         BASE_STEP     = 1222,
  parameter int         START_SHIFT   = 2,
  parameter int         START_DEFAULT = 71,
  parameter logic [7:0] LEVEL_HIGH    = 8'd126,
  parameter logic [7:0] LEVEL_LOW     = 8'd16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWe,
  input  logic [2:0]          regAddr,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  input  logic                targetLine,
  input  logic                fieldOdd,
  input  logic [SAMPLE_W-1:0] sampleCount,
  input  logic                ttxActive,
  output logic [7:0]          lumaOut,
  output logic                lumaValid
);
  capStrobe_t strobe;
  logic [7:0] sendA, sendB;

  capt_ctrl #(
    .SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W), .BASE_STEP(BASE_STEP),
    .START_SHIFT(START_SHIFT), .START_DEFAULT(START_DEFAULT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .targetLine(targetLine), .fieldOdd(fieldOdd), .sampleCount(sampleCount),
    .strobe(strobe), .sendA(sendA), .sendB(sendB)
  );

  capt_datapath #(
    .LEVEL_HIGH(LEVEL_HIGH), .LEVEL_LOW(LEVEL_LOW)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .sendA(sendA), .sendB(sendB),
    .targetLine(targetLine), .ttxActive(ttxActive),
    .lumaOut(lumaOut), .lumaValid(lumaValid)
  );
endmodule

// File: tb/caption_inserter_tb.sv
module caption_inserter_tb;
  localparam int LINE_LEN = 1716;
  localparam logic [7:0] HI = 8'd126;
  localparam logic [7:0] LO = 8'd16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd7;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        targetLine = 1'b0;
  logic        fieldOdd = 1'b1;
  logic [10:0] sampleCount = '0;
  logic        ttxActive = 1'b0;
  logic [7:0]  lumaOut;
  logic        lumaValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // bench model of the register state
  logic [7:0] mStgA [2];
  logic [7:0] mStgB [2];
  logic [7:0] mActA [2];
  logic [7:0] mActB [2];
  bit         mPend [2];
  bit         mGate;
  logic [7:0] mStart;
  logic [7:0] mTrim;

  always #10 clk = ~clk;

  caption_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .targetLine(targetLine),
    .fieldOdd(fieldOdd), .sampleCount(sampleCount), .ttxActive(ttxActive),
    .lumaOut(lumaOut), .lumaValid(lumaValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expLuma(input int prev, input int startPos, input int step,
                                         input logic [7:0] a, input logic [7:0] b);
    int m, t, k;
    m = prev - startPos;
    if (m < 1) return LO;
    t = (m - 1) * step;
    k = t >>> 16;
    if (k >= 26) return LO;
    if (k < 7) return (t[15] ? LO : HI);
    if (k == 7 || k == 8) return LO;
    if (k == 9) return HI;
    if (k < 18) return (a[k-10] ? HI : LO);
    return (b[k-18] ? HI : LO);
  endfunction

  task automatic busWrite(input logic [2:0] addr, input logic [7:0] data);
    int ch;
    @(negedge clk);
    regWe = 1'b1; regAddr = addr; regWdata = data;
    @(negedge clk);
    regWe = 1'b0; regAddr = 3'd7;
    ch = addr / 2;
    case (addr)
      3'd0, 3'd2: mStgA[ch] = data;
      3'd1, 3'd3: begin mStgB[ch] = data; mPend[ch] = 1; end
      3'd4: mGate = data[0];
      3'd5: mStart = data;
      3'd6: mTrim = data;
      default: ;
    endcase
  endtask

  task automatic readReg(input logic [2:0] addr, output logic [7:0] val);
    @(negedge clk);
    regAddr = addr;
    #1 val = regRdata;
    regAddr = 3'd7;
  endtask

  // one target line of a field; expected pair taken from the bench model
  task automatic runLine(input bit odd, input int ttxLo, input int ttxHi, input string req);
    int ch, startPos, step, bad, firstS;
    logic [7:0] a, b, expL, gotL;
    bit expV, gotV;
    ch = odd ? 0 : 1;
    if (mPend[ch]) begin
      mActA[ch] = mStgA[ch]; mActB[ch] = mStgB[ch];
      a = mStgA[ch]; b = mStgB[ch]; mPend[ch] = 0;
    end else if (mGate) begin
      a = 8'h80; b = 8'h80;
    end else begin
      a = mActA[ch]; b = mActB[ch];
    end
    startPos = int'(mStart) * 4;
    step = 1222 + int'($signed(mTrim));
    bad = 0; firstS = -1; gotL = 0; expL = 0; gotV = 0; expV = 0;
    for (int sc = 0; sc <= LINE_LEN; sc++) begin
      @(negedge clk);
      if (sc > 0) begin
        bit pv;
        logic [7:0] pl;
        pv = !((sc - 1) >= ttxLo && (sc - 1) < ttxHi);
        pl = pv ? expLuma(sc - 1, startPos, step, a, b) : LO;
        if (lumaOut !== pl || lumaValid !== pv) begin
          if (bad == 0) begin
            firstS = sc - 1; gotL = lumaOut; expL = pl; gotV = lumaValid; expV = pv;
          end
          bad++;
        end
      end
      fieldOdd = odd;
      targetLine = (sc < LINE_LEN);
      sampleCount = 11'(sc < LINE_LEN ? sc : 0);
      ttxActive = (sc >= ttxLo && sc < ttxHi);
    end
    ttxActive = 1'b0;
    if (bad != 0)
      $display("FAIL %s line sample %0d luma %0d/%0d valid %0d/%0d", req, firstS,
               gotL, expL, gotV, expV);
    check(bad == 0, req, {gotL, 7'd0, gotV}, {expL, 7'd0, expV});
  endtask

  task automatic checkStatus(input string req);
    logic [7:0] s;
    readReg(3'd7, s);
    check(s == {6'd0, 1'(mPend[1]), 1'(mPend[0])}, req, s, {6'd0, 1'(mPend[1]), 1'(mPend[0])});
  endtask

  task automatic gapCheck();
    int bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      targetLine = 1'b0;
      if (i > 0 && (lumaValid !== 1'b0 || lumaOut !== LO)) bad++;
    end
    check(bad == 0, "R11 off-line valid low", bad, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_c0de));
    for (int c = 0; c < 2; c++) begin
      mStgA[c] = 8'h80; mStgB[c] = 8'h80; mActA[c] = 8'h80; mActB[c] = 8'h80; mPend[c] = 0;
    end
    mGate = 1; mStart = 8'd71; mTrim = 8'd0;
    repeat (4) @(negedge clk);
    // R13 reset state
    check(lumaOut == LO && lumaValid == 1'b0, "R13 reset outputs", {lumaOut, 7'd0, lumaValid}, {LO, 8'd0});
    rst_n = 1'b1;
    readReg(3'd4, v); check(v == 8'd1, "R13 gate reset", v, 1);
    readReg(3'd5, v); check(v == 8'd71, "R13 start reset", v, 71);
    readReg(3'd6, v); check(v == 8'd0, "R13 trim reset", v, 0);
    readReg(3'd7, v); check(v == 8'd0, "R13 status reset", v, 0);
    gapCheck();
    // R13 null pair sent before any write
    runLine(1'b1, LINE_LEN, LINE_LEN, "R13 null burst caption");

    // R1 R2 R5 R7: fresh pair with bit 7 set, gate at 1
    busWrite(3'd0, 8'hC1);
    busWrite(3'd1, 8'hB5);
    checkStatus("R9 caption status set");
    // R6 R12: extended-data line leaves the caption pair pending
    runLine(1'b0, LINE_LEN, LINE_LEN, "R12 field two uses its own channel");
    checkStatus("R6 pending kept across other field");
    runLine(1'b1, LINE_LEN, LINE_LEN, "R1 R5 fresh caption burst");
    checkStatus("R9 caption status cleared after encode");
    runLine(1'b1, LINE_LEN, LINE_LEN, "R7 gate one falls back to null");
    gapCheck();

    // R8: gate 0 repeats the last pair
    busWrite(3'd4, 8'd0);
    busWrite(3'd2, 8'h3C);
    busWrite(3'd3, 8'h07);
    checkStatus("R9 extended status set");
    runLine(1'b0, LINE_LEN, LINE_LEN, "R12 extended burst");
    runLine(1'b0, LINE_LEN, LINE_LEN, "R8 gate zero repeats");
    runLine(1'b1, LINE_LEN, LINE_LEN, "R8 caption repeats old pair");

    // R3 R4: trimmed step and moved start
    busWrite(3'd6, 8'd100);
    busWrite(3'd5, 8'd40);
    runLine(1'b1, LINE_LEN, LINE_LEN, "R3 R4 fast step early start");
    busWrite(3'd6, 8'hF6);
    busWrite(3'd5, 8'd72);
    runLine(1'b0, LINE_LEN, LINE_LEN, "R3 slow step late start");

    // R10: teletext window across the run-in and data
    runLine(1'b1, 400, 900, "R10 teletext wins mid burst");
    runLine(1'b0, 0, 5, "R10 teletext at line start");

    // random frames
    for (int f = 0; f < 10; f++) begin
      if ($urandom_range(1, 0) == 1) begin
        busWrite(3'd0, 8'($urandom()));
        busWrite(3'd1, 8'($urandom()));
      end
      if ($urandom_range(2, 0) == 0) begin
        busWrite(3'd2, 8'($urandom()));
        busWrite(3'd3, 8'($urandom()));
      end
      if ($urandom_range(3, 0) == 0) busWrite(3'd4, {7'd0, ~mGate});
      busWrite(3'd6, 8'($signed($urandom_range(50, 0)) - 10));
      busWrite(3'd5, 8'($urandom_range(72, 60)));
      checkStatus("R9 random status before lines");
      if ($urandom_range(3, 0) == 0) begin
        int lo = int'($urandom_range(1500, 0));
        runLine(1'b1, lo, lo + 60, "R10 R7 R8 random caption line");
      end else begin
        runLine(1'b1, LINE_LEN, LINE_LEN, "R1 R7 R8 random caption line");
      end
      runLine(1'b0, LINE_LEN, LINE_LEN, "R12 random extended line");
      checkStatus("R9 random status after lines");
      gapCheck();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule